// File: doc/BRIEF.md
# Up-Counting Timer with Prescaler and One Capture/Compare Channel

The block is a general-purpose timer driven by a single system clock. A programmable prescaler turns that clock into counting ticks. An up-counter steps on each tick from zero to a programmed period, then returns to zero and gives a one-cycle overflow pulse. One channel sits next to the counter and has two modes. In output mode it compares the counter with a channel value and drives a pulse-width waveform. In input mode it stores the counter value when a rising edge arrives on the channel input.

Software sets the block up through a simple write port. Some writes do not take effect at once: a new prescaler value always waits for the next overflow, and so does a new compare value when buffering is on. This lets the rate or the duty cycle change without a glitch in the middle of a period. A wide-mode bit chooses between a 16-bit and a 32-bit counter, period and channel value.

Top module: `tmr_cc_top`

## Requirements
- R1: After reset, cnt, ovf, chOut, chData and capFlag are all 0, and every internal register is 0.
- R2: The write port stores wrData at the address on wrAddr when wrEn is high. Address 0 is the control word: bit0 run, bit1 input-capture mode, bit2 compare buffering, bit3 wide mode. While run is 1, the counter gets one tick every (active divider + 1) clock cycles. While run is 0, the counter and the prescaler hold their values.
- R3: With a nonzero effective period, the counter steps from 0 up to the period. ovf is high for exactly the one cycle in which a tick arrives while the counter equals the period. On that tick the counter goes to 0.
- R4: A write to address 1 (divider, bits 15:0) goes into a pending register. The pending value becomes the active divider only on an overflow. The active divider is 0 after reset.
- R5: A write to address 2 sets the period. When the effective period is 0, the counter does not change and ovf stays low.
- R6: When wide mode is 1, the period, the channel value and the counter are used as 32 bits. When wide mode is 0, only their low 16 bits take part in matching and comparing, and the counter wraps within 16 bits.
- R7: In output mode, chOut is 1 while the effective counter is below the effective active channel value, and 0 otherwise. In input-capture mode, chOut is 0.
- R8: A write to address 3 sets the channel value. If buffering is 0, the active value (shown on chData) changes on the write edge. If buffering is 1, the value goes into a shadow register, and the shadow is copied to the active value on the next overflow.
- R9: chIn passes through two synchroniser flops. Let edge k be the first clock edge that samples chIn high after it was low. In input-capture mode, at edge k+3 chData takes the effective counter value held just before that edge, and capFlag becomes 1.
- R10: Writing address 4 with bit0 = 1 clears capFlag. A capture in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| chIn | input | 1 | Asynchronous channel capture input |
| cnt | output | 32 | Counter value |
| ovf | output | 1 | One-cycle overflow pulse |
| chOut | output | 1 | Compare output |
| chData | output | 32 | Active channel value (compare value or last capture) |
| capFlag | output | 1 | Capture-occurred flag |

## Verification
The counter is run with a divider of 0 and with a divider written while the counter runs. The first case shows whether the timer counts on every clock. The second shows whether the new rate waits for an overflow. A zero period and a stop of the run bit show whether the counter really halts. A period above 16 bits, run once in wide mode and once in narrow mode, shows whether the 16-bit wrap and the period masking are correct. In output mode, every compare value from 0 to past the period is swept, both immediate and buffered, which tells apart an off-by-one compare and an early shadow load. In input mode, repeated pulses and flag clears check the three-edge capture latency and the set-over-clear priority.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_DIV  = 3'd1;
  localparam logic [2:0] ADDR_PER  = 3'd2;
  localparam logic [2:0] ADDR_DATA = 3'd3;
  localparam logic [2:0] ADDR_FLAG = 3'd4;

  // strobes and live configuration from control to datapath
  typedef struct packed {
    logic tick;
    logic capture;
    logic perWr;
    logic dataWr;
    logic capMode;
    logic bufEn;
    logic wide;
  } tmrStrb_t;
endpackage

// File: rtl/tmr_cc_ctrl.sv
module tmr_cc_ctrl
  import tmr_cc_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [DIV_W-1:0] wrLow,
  input  logic             chIn,
  input  logic             ovfEv,
  output tmrStrb_t         strb,
  output logic             capFlag
);
  logic             runEn, capMode, bufEn, wide;
  logic [DIV_W-1:0] divPend, divAct, presCnt;
  logic [SYNC_N:0]  syncQ;
  logic             capStb, rise, tick;

  assign tick = runEn && (presCnt == divAct);
  assign rise = syncQ[SYNC_N-1] & ~syncQ[SYNC_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      capMode <= 1'b0;
      bufEn   <= 1'b0;
      wide    <= 1'b0;
      divPend <= '0;
      divAct  <= '0;
      presCnt <= '0;
      syncQ   <= '0;
      capStb  <= 1'b0;
      capFlag <= 1'b0;
    end else begin
      if (wrEn && wrAddr == ADDR_CTRL) begin
        runEn   <= wrLow[0];
        capMode <= wrLow[1];
        bufEn   <= wrLow[2];
        wide    <= wrLow[3];
      end
      if (wrEn && wrAddr == ADDR_DIV) divPend <= wrLow;
      if (ovfEv) divAct <= divPend;
      if (tick) presCnt <= '0;
      else if (runEn) presCnt <= presCnt + 1'b1;
      syncQ  <= {syncQ[SYNC_N-1:0], chIn};
      capStb <= rise;
      if (capStb && capMode) capFlag <= 1'b1;
      else if (wrEn && wrAddr == ADDR_FLAG && wrLow[0]) capFlag <= 1'b0;
    end
  end

  always_comb begin
    strb.tick    = tick;
    strb.capture = capStb && capMode;
    strb.perWr   = wrEn && wrAddr == ADDR_PER;
    strb.dataWr  = wrEn && wrAddr == ADDR_DATA;
    strb.capMode = capMode;
    strb.bufEn   = bufEn;
    strb.wide    = wide;
  end

  a_r2_prescaler_holds: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> $stable(presCnt));
  a_r4_div_waits: assert property (@(posedge clk) disable iff (!rstN)
    !ovfEv |=> $stable(divAct));
  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> capFlag);
endmodule

// File: rtl/tmr_cc_dpath.sv
module tmr_cc_dpath
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrb_t         strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic             ovfEv,
  output logic             chOut,
  output logic [CNT_W-1:0] chData
);
  localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] per, dataAct, dataShadow;
  logic [CNT_W-1:0] mask, perEff, cntEff, dataEff;

  assign mask    = strb.wide ? '1 : NARROW_MASK;
  assign perEff  = per & mask;
  assign cntEff  = cnt & mask;
  assign dataEff = dataAct & mask;
  assign ovfEv   = strb.tick && (perEff != '0) && (cntEff == perEff);
  assign chOut   = !strb.capMode && (cntEff < dataEff);
  assign chData  = dataAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      per        <= '0;
      cnt        <= '0;
      dataAct    <= '0;
      dataShadow <= '0;
    end else begin
      if (strb.perWr) per <= wrData;
      if (strb.tick && perEff != '0)
        cnt <= ovfEv ? '0 : ((cnt + ONE) & mask);
      if (strb.dataWr) dataShadow <= wrData;
      if (strb.capture) dataAct <= cntEff;
      else if (strb.dataWr && !strb.bufEn) dataAct <= wrData;
      else if (ovfEv && strb.bufEn) dataAct <= dataShadow;
    end
  end

  a_r3_ovf_wraps: assert property (@(posedge clk) disable iff (!rstN)
    ovfEv |=> cnt == '0);
  a_r3_ovf_single: assert property (@(posedge clk) disable iff (!rstN)
    ovfEv |=> !ovfEv);
  a_r5_zero_holds: assert property (@(posedge clk) disable iff (!rstN)
    (perEff == '0) |=> $stable(cnt));
  a_r8_buffered_waits: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capMode && strb.bufEn && !ovfEv) |=> $stable(dataAct));
endmodule

// File: rtl/tmr_cc_top.sv
module tmr_cc_top
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16,
  parameter int DIV_W    = 16,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             chIn,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             chOut,
  output logic [CNT_W-1:0] chData,
  output logic             capFlag
);
  tmrStrb_t strb;
  logic     ovfEv;

  tmr_cc_ctrl #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrLow(wrData[DIV_W-1:0]), .chIn(chIn), .ovfEv(ovfEv),
    .strb(strb), .capFlag(capFlag)
  );

  tmr_cc_dpath #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .cnt(cnt), .ovfEv(ovfEv), .chOut(chOut), .chData(chData)
  );

  assign ovf = ovfEv;
endmodule

// File: tb/tmr_cc_top_tb_top.sv
module tmr_cc_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = 3'd0;
  logic [31:0] wrData = 32'd0;
  logic        chIn = 1'b0;
  logic [31:0] cnt, chData;
  logic        ovf, chOut, capFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit chkOn = 1'b0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  tmr_cc_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chIn(chIn), .cnt(cnt), .ovf(ovf), .chOut(chOut), .chData(chData),
    .capFlag(capFlag)
  );

  // behavioural model built from the requirements
  logic        mRun, mCap, mBuf, mWide, mFlag;
  logic [15:0] mDivP, mDivA, mPc;
  logic [31:0] mPer, mCnt, mAct, mShd;
  logic        m1, m2, m3, mStb;

  function automatic logic [31:0] msk(input logic w);
    return w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 0; mCap = 0; mBuf = 0; mWide = 0; mFlag = 0;
      mDivP = 0; mDivA = 0; mPc = 0; mPer = 0; mCnt = 0; mAct = 0; mShd = 0;
      m1 = 0; m2 = 0; m3 = 0; mStb = 0;
    end else begin
      automatic logic [31:0] m = msk(mWide);
      automatic logic [31:0] pe = mPer & m;
      automatic logic tk = mRun && (mPc == mDivA);
      automatic logic ov = tk && pe != 0 && (mCnt & m) == pe;
      automatic logic cap = mStb && mCap;
      automatic logic [31:0] cntOld = mCnt & m;
      automatic logic oldBuf = mBuf;
      automatic logic [31:0] shdOld = mShd;
      if (tk) mPc = 0; else if (mRun) mPc = mPc + 1;
      if (tk && pe != 0) mCnt = ov ? 0 : ((mCnt + 1) & m);
      if (ov) mDivA = mDivP;
      if (cap) mFlag = 1;
      else if (wrEn && wrAddr == 4 && wrData[0]) mFlag = 0;
      if (cap) mAct = cntOld;
      else if (wrEn && wrAddr == 3 && !oldBuf) mAct = wrData;
      else if (ov && oldBuf) mAct = shdOld;
      if (wrEn) begin
        case (wrAddr)
          3'd0: begin mRun = wrData[0]; mCap = wrData[1]; mBuf = wrData[2]; mWide = wrData[3]; end
          3'd1: mDivP = wrData[15:0];
          3'd2: mPer = wrData;
          3'd3: mShd = wrData;
          default: ;
        endcase
      end
      mStb = m2 & ~m3;
      m3 = m2; m2 = m1; m1 = chIn;
    end
  end

  task automatic chk1(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      automatic logic [31:0] m = msk(mWide);
      automatic logic tk = mRun && (mPc == mDivA);
      automatic logic ov = tk && (mPer & m) != 0 && (mCnt & m) == (mPer & m);
      chk1("cnt", cnt, mCnt);
      chk1("ovf", {31'd0, ovf}, {31'd0, ov});
      chk1("chOut", {31'd0, chOut}, {31'd0, !mCap && ((mCnt & m) < (mAct & m))});
      chk1("chData", chData, mAct);
      chk1("capFlag", {31'd0, capFlag}, {31'd0, mFlag});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; wrData = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    chkOn = 0;
    @(negedge clk); rstN = 0; chIn = 0;
    idle(2);
    rstN = 1;
    chkOn = 1;
  endtask

  function automatic logic [31:0] cw(input logic run, input logic capM, input logic bufE, input logic wideE);
    return {28'd0, wideE, bufE, capM, run};
  endfunction

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); chIn = 1;
    idle(hi);
    chIn = 0;
    idle(lo);
  endtask

  initial begin
    // R1 reset state
    curReq = "R1";
    doReset();
    idle(3);
    // R2, R3: divider 0, period 5
    curReq = "R3";
    wr(2, 5); wr(0, cw(1, 0, 0, 0));
    idle(30);
    // R2: stopping freezes everything
    curReq = "R2";
    wr(0, cw(0, 0, 0, 0)); idle(10);
    wr(0, cw(1, 0, 0, 0)); idle(10);
    // R5: zero period halts
    curReq = "R5";
    doReset(); wr(0, cw(1, 0, 0, 0)); idle(20);
    wr(2, 3); idle(12); wr(2, 0); idle(10);
    // R4: divider waits for overflow
    curReq = "R4";
    doReset(); wr(2, 4); wr(1, 2); wr(0, cw(1, 0, 0, 0));
    idle(60); wr(1, 0); idle(40); wr(1, 5); idle(80);
    // R6: wide vs narrow with a period above 16 bits
    curReq = "R6";
    doReset(); wr(2, 32'h0001_0003); wr(3, 32'h0001_0001); wr(0, cw(1, 0, 0, 1));
    idle(65545);
    doReset(); wr(2, 32'h0001_0003); wr(3, 32'h0001_0002); wr(0, cw(1, 0, 0, 0));
    idle(20);
    // R7: sweep of compare values, unbuffered
    curReq = "R7";
    doReset(); wr(2, 7); wr(0, cw(1, 0, 0, 0));
    for (int c = 0; c < 10; c++) begin
      wr(3, c); idle(17);
    end
    // R8: buffered compare values, written at varied phases
    curReq = "R8";
    doReset(); wr(2, 7); wr(3, 3); wr(0, cw(1, 0, 1, 0));
    idle(12);
    for (int c = 0; c < 10; c++) begin
      wr(3, 9 - c); idle(3 + c);
    end
    wr(0, cw(1, 0, 0, 0)); wr(3, 2); idle(12);
    // R9: capture on rising edges
    curReq = "R9";
    doReset(); wr(2, 50); wr(0, cw(1, 1, 0, 0));
    for (int p = 0; p < 6; p++) pulse(2 + p, 5 + 3 * p);
    // R10: clear flag, then capture racing a clear
    curReq = "R10";
    wr(4, 1); idle(5);
    wr(4, 0); idle(3);
    pulse(2, 1);
    wr(4, 1); idle(6);
    @(negedge clk); chIn = 1; idle(2);
    wr(4, 1); chIn = 0; idle(8);
    wr(4, 1); idle(4);
    chkOn = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule